// File: doc/BRIEF.md
# Framed Serial Command Decoder

This block receives 16-bit command words over a three-line serial link (an active-low frame strobe, a serial clock and one data line) and turns each complete word into a single write pulse for a converter's register core. Bits are taken most significant first, one per falling serial-clock edge while the frame strobe is low. All three lines are brought into the system clock domain through two-flop synchronizers, and the serial clock's falling edge is found there, so every output is a plain register in the system clock domain.

Once sixteen bits have arrived, the word is split into a register class, a channel address and a payload. Two mode bits and the top select bit together choose among the global control register, a per-channel control register, and a channel's main or fine-offset data register. A frame cut short is dropped, and bits clocked past the sixteenth are not used. The register storage lives elsewhere; this block only issues the pulses.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset `wrValid` is 0 and `wrKind`, `wrAddr` and `wrData` are all 0.
- R2: While `serFrameN` is low, each falling edge of `serClk` captures `serData` into the word, the first bit being bit 15. The sixteenth captured bit of a frame produces exactly one write pulse.
- R3: Word bits 14 and 13 both 0 select the global control register. `wrKind` is then 0, `wrAddr` is 0 whatever bits 12..10 hold, and `wrData` is word bits 9..0.
- R4: Bit 14 = 1 with bit 13 = 0 selects a channel control register. `wrKind` is then 1, `wrAddr` is bits 12..10 and `wrData` is bits 9..0.
- R5: Bit 13 = 1 selects a data register whatever bit 14 holds. With bit 15 = 0 the target is the main register: `wrKind` is 2, `wrAddr` is bits 12..10 and `wrData` is bits 9..0.
- R6: Bit 13 = 1 with bit 15 = 1 targets the fine-offset register. `wrKind` is 3 and `wrData` is {2'b00, bits 9..2}, so bits 1 and 0 have no effect.
- R7: A frame that ends after fewer than sixteen bits produces no pulse. The next full frame decodes correctly.
- R8: Bits clocked after the sixteenth in one frame produce no further pulse and leave the outputs unchanged.
- R9: When `NUM_CH` is 4, address bit 2 is treated as don't-care, so `wrAddr[2]` is always 0.
- R10: `wrValid` is high for exactly one system clock cycle per decoded word.
- R11: Serial-clock edges while `serFrameN` is high capture nothing and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial bit clock; data is taken on its falling edge |
| serFrameN | input | 1 | Active-low frame strobe |
| serData | input | 1 | Serial data, MSB first |
| wrValid | output | 1 | One-cycle write pulse |
| wrKind | output | 2 | 0 global control, 1 channel control, 2 main data, 3 fine-offset data |
| wrAddr | output | 3 | Channel address |
| wrData | output | 10 | Write payload |

## Verification
The hardest cases to reach are frames whose length is not sixteen. The decoder has to drop a short frame, and it has to ignore the tail of an overlong one without raising a second pulse. The bench drives the three serial lines bit by bit through one task that takes any bit count, so it can send 9-bit and 20-bit frames as well as clock edges with the frame strobe held high. It then checks the pulse count and the outputs before the next frame begins. A second instance built for four channels shares the same inputs, which shows the don't-care address bit being masked.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  typedef enum logic [1:0] {
    KIND_SYS  = 2'd0,
    KIND_CHAN = 2'd1,
    KIND_MAIN = 2'd2,
    KIND_SUB  = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic shiftEn;
    logic lastBit;
  } sdec_strobe_t;

endpackage

// File: rtl/sdec_ctrl.sv
module sdec_ctrl
  import sdec_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serFrameN,
  input  logic         serData,
  output sdec_strobe_t stb,
  output logic         dataS
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [SYNC_LEN-1:0] clkPipe, framePipe, dataPipe;
  logic                clkS, frameS, prevClk, fallEdge;
  logic [CNT_W-1:0]    bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPipe   <= '0;
      framePipe <= '1;
      dataPipe  <= '0;
      prevClk   <= 1'b0;
    end else begin
      clkPipe   <= {clkPipe[SYNC_LEN-2:0], serClk};
      framePipe <= {framePipe[SYNC_LEN-2:0], serFrameN};
      dataPipe  <= {dataPipe[SYNC_LEN-2:0], serData};
      prevClk   <= clkS;
    end
  end

  assign clkS     = clkPipe[SYNC_LEN-1];
  assign frameS   = framePipe[SYNC_LEN-1];
  assign dataS    = dataPipe[SYNC_LEN-1];
  assign fallEdge = prevClk & ~clkS;

  always_comb begin
    stb.shiftEn = fallEdge & ~frameS & (bitCnt < CNT_W'(WORD_W));
    stb.lastBit = stb.shiftEn & (bitCnt == CNT_W'(WORD_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || frameS) begin
      bitCnt <= '0;
    end else if (stb.shiftEn) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdec_datapath.sv
module sdec_datapath
  import sdec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_W = 10,
  parameter int SUB_W  = 8,
  parameter int ADDR_W = 3,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdec_strobe_t      stb,
  input  logic              dataS,
  output logic              wrValid,
  output wr_kind_e          wrKind,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int SEL_BIT  = WORD_W - 1;
  localparam int MD0_BIT  = WORD_W - 2;
  localparam int MD1_BIT  = WORD_W - 3;
  localparam int ADDR_LO  = MD1_BIT - ADDR_W;
  localparam int USED_A   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SUB_LO   = DATA_W - SUB_W;

  logic [WORD_W-1:0] shiftReg, nextWord;
  logic [ADDR_W-1:0] rawAddr, maskAddr;
  wr_kind_e          kindDec;
  logic [DATA_W-1:0] dataDec;

  assign nextWord = {shiftReg[WORD_W-2:0], dataS};
  assign rawAddr  = nextWord[ADDR_LO +: ADDR_W];

  for (genvar i = 0; i < ADDR_W; i++) begin : g_amask
    if (i < USED_A) begin : g_keep
      assign maskAddr[i] = rawAddr[i];
    end else begin : g_drop
      assign maskAddr[i] = 1'b0;
    end
  end

  always_comb begin
    dataDec = nextWord[DATA_W-1:0];
    if (nextWord[MD1_BIT]) begin
      if (nextWord[SEL_BIT]) begin
        kindDec = KIND_SUB;
        dataDec = {{SUB_LO{1'b0}}, nextWord[DATA_W-1:SUB_LO]};
      end else begin
        kindDec = KIND_MAIN;
      end
    end else if (nextWord[MD0_BIT]) begin
      kindDec = KIND_CHAN;
    end else begin
      kindDec = KIND_SYS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      wrValid  <= 1'b0;
      wrKind   <= KIND_SYS;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrValid <= stb.lastBit;
      if (stb.shiftEn) shiftReg <= nextWord;
      if (stb.lastBit) begin
        wrKind <= kindDec;
        wrAddr <= (kindDec == KIND_SYS) ? '0 : maskAddr;
        wrData <= dataDec;
      end
    end
  end

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import sdec_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int DATA_W   = 10,
  parameter int SUB_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_CH   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serFrameN,
  input  logic              serData,
  output logic              wrValid,
  output logic [1:0]        wrKind,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  sdec_strobe_t stb;
  logic         dataS;
  wr_kind_e     kindQ;

  sdec_ctrl #(.WORD_W(WORD_W), .SYNC_LEN(SYNC_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serFrameN(serFrameN),
    .serData(serData), .stb(stb), .dataS(dataS)
  );

  sdec_datapath #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .SUB_W(SUB_W),
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataS(dataS),
    .wrValid(wrValid), .wrKind(kindQ), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign wrKind = kindQ;

endmodule

// File: rtl/serial_cmd_decoder_chk.sv
module serial_cmd_decoder_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 10,
  parameter int SUB_W  = 8,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [1:0]        wrKind,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData
);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  p_sys_addr_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrKind == 2'd0) |-> (wrAddr == '0));

  p_sub_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrKind == 2'd3) |-> (wrData[DATA_W-1:SUB_W] == '0));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> ($stable(wrData) && $stable(wrAddr) && $stable(wrKind)));

  if (NUM_CH <= 4) begin : g_quad
    p_quad_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
      wrAddr[ADDR_W-1] == 1'b0);
  end

endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_W(SUB_W), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrKind(wrKind),
  .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/sim_serial_cmd_decoder.sv
`timescale 1ns/1ps
module sim_serial_cmd_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sClk = 1'b0, sFrameN = 1'b1, sData = 1'b0;
  logic       wrValid, wrValid1;
  logic [1:0] wrKind, wrKind1;
  logic [2:0] wrAddr, wrAddr1;
  logic [9:0] wrData, wrData1;

  int checks = 0, errors = 0;
  int pulses = 0, highCycles = 0;
  logic [1:0] lastKind;
  logic [2:0] lastAddr, lastAddr1;
  logic [9:0] lastData;

  always #2.5 clk = ~clk;

  serial_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .serClk(sClk), .serFrameN(sFrameN), .serData(sData),
    .wrValid(wrValid), .wrKind(wrKind), .wrAddr(wrAddr), .wrData(wrData)
  );

  serial_cmd_decoder #(.NUM_CH(4)) u1 (
    .clk(clk), .rstN(rstN), .serClk(sClk), .serFrameN(sFrameN), .serData(sData),
    .wrValid(wrValid1), .wrKind(wrKind1), .wrAddr(wrAddr1), .wrData(wrData1)
  );

  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (wrValid) begin
      highCycles++;
      if (!prevValid) begin
        pulses++;
        lastKind  = wrKind;
        lastAddr  = wrAddr;
        lastData  = wrData;
        lastAddr1 = wrAddr1;
      end
    end
    prevValid = wrValid;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitSys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int n, input bit useFrame);
    if (useFrame) sFrameN = 1'b0;
    waitSys(4);
    for (int i = n - 1; i >= 0; i--) begin
      sData = w[i];
      sClk  = 1'b1;
      waitSys(4);
      sClk  = 1'b0;
      waitSys(4);
    end
    waitSys(4);
    sFrameN = 1'b1;
    waitSys(6);
  endtask

  task automatic sendWord(input string req, input logic [15:0] w,
                          input int kind, input int addr, input int data);
    int p0 = pulses;
    sendBits({16'h0, w}, 16, 1'b1);
    check({req, " pulse count"}, pulses - p0, 1);
    check({req, " kind"}, lastKind, kind);
    check({req, " addr"}, lastAddr, addr);
    check({req, " data"}, lastData, data);
  endtask

  task automatic t_reset();
    check("R1 valid", wrValid, 0);
    check("R1 kind", wrKind, 0);
    check("R1 addr", wrAddr, 0);
    check("R1 data", wrData, 0);
  endtask

  task automatic t_system();
    sendWord("R2 R3 sys 0060", 16'h0060, 0, 0, 10'h060);
    sendWord("R3 sys 0020", 16'h0020, 0, 0, 10'h020);
    sendWord("R3 sys addr ignored", 16'h1C20, 0, 0, 10'h020);
  endtask

  task automatic t_channel();
    sendWord("R4 chan 4110", 16'h4110, 1, 0, 10'h110);
    sendWord("R4 chan addr7", 16'h5C01, 1, 7, 10'h001);
  endtask

  task automatic t_main();
    sendWord("R5 main 2200", 16'h2200, 2, 0, 10'h200);
    sendWord("R5 main md0 set", 16'h7D55, 2, 7, 10'h155);
  endtask

  task automatic t_sub();
    sendWord("R6 sub A200", 16'hA200, 3, 0, 10'h080);
    sendWord("R6 sub low bits", 16'hA603, 3, 1, 10'h080);
  endtask

  task automatic t_short();
    int p0 = pulses;
    sendBits(32'h1FF, 9, 1'b1);
    check("R7 short frame no pulse", pulses - p0, 0);
    check("R7 outputs held", wrData, 10'h080);
    sendWord("R7 after short", 16'h2200, 2, 0, 10'h200);
  endtask

  task automatic t_long();
    int p0 = pulses;
    sendBits({12'h0, 16'h4110, 4'hF}, 20, 1'b1);
    check("R8 long frame one pulse", pulses - p0, 1);
    check("R8 data from first 16", wrData, 10'h110);
    check("R8 kind", wrKind, 1);
  endtask

  task automatic t_idle();
    int p0 = pulses;
    sendBits(32'hFFFF, 16, 1'b0);
    check("R11 no pulse with frame high", pulses - p0, 0);
    check("R11 outputs held", wrData, 10'h110);
  endtask

  task automatic t_quad();
    sendBits({16'h0, 16'h3D55}, 16, 1'b1);
    check("R9 octal addr", lastAddr, 7);
    check("R9 quad addr", lastAddr1, 3);
  endtask

  initial begin
    waitSys(5);
    rstN = 1'b1;
    waitSys(3);
    t_reset();
    t_system();
    t_channel();
    t_main();
    t_sub();
    t_short();
    t_long();
    t_idle();
    t_quad();
    check("R10 single cycle pulses", highCycles, pulses);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule